// File: doc/BRIEF.md
# Single-Channel DMA Sequencer with Descriptor Chaining

This block drives one DMA channel. It takes 32-bit words from a streaming source and writes each one to a memory port, at an address that it generates. Each accepted word moves the address by a signed byte stride held in a register. Software can set up a transfer in two ways. It can load the start address, word count and stride directly and then write the configuration register. Or it can give the channel a pointer to a descriptor set in memory, which the channel reads over a separate descriptor port before any data moves.

There are four modes:

- **One-shot:** runs a single buffer and then halts.
- **Autorefresh:** reloads the setup that software programmed each time the buffer completes, so the same buffer repeats without end.
- **Linked list:** reads four words per sequence (next pointer, address, length, configuration) and follows the next pointer after each sequence.
- **Ping-pong ring:** reads only a next pointer and an address per sequence and keeps the length and configuration it already has.

The channel can raise an interrupt pulse when a buffer completes, another at its midpoint, and a sticky error flag when a descriptor carries a length of zero.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset the channel is idle: `busy`, `wr_valid`, `src_ready`, `dsc_rd`, `irq_done`, `irq_half` and `err` are all 0.
- R2: A write to select 3 (configuration) while idle starts the channel. The configuration word has these fields:
  - bits [2:0] are the mode: 0 one-shot, 1 autorefresh, 2 linked list, 3 ping-pong ring, and 4 to 7 behave as one-shot;
  - bit 3 enables the completion interrupt;
  - bit 4 enables the midpoint interrupt.

  The other register selects are: 0 start address, 1 word count, 2 stride, 4 descriptor pointer. In one-shot mode, word k of the buffer (k from 0 to count-1) is written to address start + k*stride, with `wr_data` equal to `src_data`. The channel then goes idle.
- R3: The stride is a signed two's-complement byte step and may be positive, negative or zero. While `wr_valid` is high and `wr_ready` is low, `wr_addr` holds its value.
- R4: In autorefresh mode the channel restarts from the programmed start address and count after every completed buffer, with no software action.
- R5: When bit 3 is set, `irq_done` is high for exactly one cycle, in the cycle after the last word of a buffer is accepted.
- R6: When bit 4 is set and the count N is at least 2, `irq_half` is high for one cycle, in the cycle after word number floor(N/2) is accepted. Words are counted from 1.
- R7: In linked-list mode the channel reads four words at pointer, pointer+4, pointer+8 and pointer+12, in that order: next pointer, start address, word count, configuration. The configuration read this way governs the sequence it describes.
- R8: In ping-pong mode the channel reads two words, next pointer and then start address. It keeps the current word count and configuration.
- R9: No data word is offered while a descriptor read is pending. Transfer begins only after the last word of the set has been accepted.
- R10: When a sequence ends in linked-list or ping-pong mode, the channel fetches the set at the stored next pointer and continues by itself.
- R11: A start with a word count of zero sets `err` and leaves the channel idle with no data written. The count can come from a register or from a fetched descriptor. `err` stays set until the next start that has a nonzero count.
- R12: Register writes while `busy` is high have no effect. A running autorefresh loop keeps its original address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select (0 addr, 1 count, 2 stride, 3 config/start, 4 pointer) |
| reg_wr_data | input | AW | Register write data |
| dsc_rd | output | 1 | Descriptor read request |
| dsc_addr | output | AW | Descriptor word address |
| dsc_ack | input | 1 | Descriptor read accepted, data valid |
| dsc_data | input | AW | Descriptor word |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Source word taken |
| src_data | input | DW | Source word |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |
| irq_done | output | 1 | Buffer-complete pulse |
| irq_half | output | 1 | Midpoint pulse |
| err | output | 1 | Sticky zero-length error |
| busy | output | 1 | Channel active |

## Verification
One-shot transfers are swept over word counts 1 to 6 and strides of -4, 0, +4 and +12, with the handshake inputs stalled in an irregular pattern. The sweep separates the address arithmetic from the handshake, checks where the midpoint falls for odd and even counts, and shows that a zero stride repeats a single address. Autorefresh runs across three wraps show that the original setup is reloaded and that writes made mid-run are ignored. A two-element linked list and a two-entry ping-pong ring check the order of descriptor reads, the switch of configuration between sequences, and the reuse of the count. Zero-length starts from both a descriptor and a register check the error path and the way the flag is cleared.

// File: rtl/dmac_pkg.sv
// Shared definitions for the DMA channel sequencer.
// Assumes a 5-bit configuration field in the low bits of a register word.
package dmac_pkg;

    localparam logic [2:0] MODE_ONESHOT = 3'd0;
    localparam logic [2:0] MODE_REFRESH = 3'd1;
    localparam logic [2:0] MODE_LIST    = 3'd2;
    localparam logic [2:0] MODE_RING    = 3'd3;

    localparam logic [2:0] SEL_ADDR   = 3'd0;
    localparam logic [2:0] SEL_COUNT  = 3'd1;
    localparam logic [2:0] SEL_STRIDE = 3'd2;
    localparam logic [2:0] SEL_CFG    = 3'd3;
    localparam logic [2:0] SEL_PTR    = 3'd4;

    typedef struct packed {
        logic       half_en;
        logic       done_en;
        logic [2:0] mode;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_RUN   = 2'd3
    } chan_state_e;

endpackage

// File: rtl/dmac_desc_fetch.sv
// Descriptor reader: issues one read per cycle at ptr, ptr+4, ...
// It reads two or four words and reports each accepted word with its index.
// Assumes the data is valid in the same cycle as dsc_ack.
module dmac_desc_fetch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ptr,
    input  logic          four,
    input  logic          dsc_ack,
    output logic          dsc_rd,
    output logic [AW-1:0] dsc_addr,
    output logic          take,
    output logic [1:0]    idx,
    output logic          last
);
    logic          act;
    logic          four_r;
    logic [AW-1:0] ptr_r;

    assign dsc_rd   = act;
    assign dsc_addr = ptr_r + AW'({idx, 2'b00});
    assign take     = act & dsc_ack;
    assign last     = take && (idx == (four_r ? 2'd3 : 2'd1));

    // Sequence through the words of one descriptor set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            four_r <= 1'b0;
            ptr_r  <= '0;
            idx    <= '0;
        end else if (start) begin
            act    <= 1'b1;
            four_r <= four;
            ptr_r  <= ptr;
            idx    <= '0;
        end else if (take) begin
            idx <= idx + 2'd1;
            if (last) act <= 1'b0;
        end
    end
endmodule

// File: rtl/dmac_addr_gen.sv
// Address and word-count generator for one buffer.
// It flags the final word and the midpoint word (floor(len/2)).
// Assumes len and stride stay stable between load and the final word.
module dmac_addr_gen #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] stride,
    input  logic          beat,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          half
);
    logic [LW-1:0] remain;
    logic [LW-1:0] sent;

    assign last = beat && (remain == LW'(1));
    assign half = beat && ((sent + LW'(1)) == (len >> 1));

    // Step the address and the counters on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
            sent   <= '0;
        end else if (load) begin
            addr   <= base;
            remain <= len;
            sent   <= '0;
        end else if (beat) begin
            addr   <= addr + stride;
            remain <= remain - LW'(1);
            sent   <= sent + LW'(1);
        end
    end
endmodule

// File: rtl/dmac_chan_ctrl.sv
// DMA channel sequencer top. Register-started one-shot and autorefresh
// buffers, linked-list and ping-pong descriptor chaining, interrupt pulses
// and a sticky zero-length error. Register writes are honoured only when idle.
module dmac_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_wr_sel,
    input  logic [AW-1:0] reg_wr_data,
    output logic          dsc_rd,
    output logic [AW-1:0] dsc_addr,
    input  logic          dsc_ack,
    input  logic [AW-1:0] dsc_data,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [DW-1:0] src_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          irq_done,
    output logic          irq_half,
    output logic          err,
    output logic          busy
);
    localparam int CW = $bits(chan_cfg_t);

    chan_state_e   state;
    logic [AW-1:0] addr_q, stride_q, link_q;
    logic [LW-1:0] len_q;
    chan_cfg_t     cfg_q, cfg_new;
    logic          start_wr, beat, ag_last, ag_half;
    logic          fe_start, fe_four, fe_take, fe_last;
    logic [1:0]    fe_idx;

    assign cfg_new   = chan_cfg_t'(reg_wr_data[CW-1:0]);
    assign start_wr  = (state == ST_IDLE) && reg_wr_en && (reg_wr_sel == SEL_CFG);
    assign busy      = (state != ST_IDLE);
    assign wr_valid  = (state == ST_RUN) && src_valid;
    assign src_ready = (state == ST_RUN) && wr_ready;
    assign wr_data   = src_data;
    assign beat      = wr_valid && wr_ready;

    // Decide when a descriptor fetch begins and how many words it reads.
    always_comb begin
        fe_start = 1'b0;
        fe_four  = 1'b0;
        if (start_wr && (cfg_new.mode == MODE_LIST || cfg_new.mode == MODE_RING)) begin
            fe_start = 1'b1;
            fe_four  = (cfg_new.mode == MODE_LIST);
        end else if ((state == ST_RUN) && ag_last &&
                     (cfg_q.mode == MODE_LIST || cfg_q.mode == MODE_RING)) begin
            fe_start = 1'b1;
            fe_four  = (cfg_q.mode == MODE_LIST);
        end
    end

    dmac_desc_fetch #(.AW(AW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fe_start), .ptr(link_q), .four(fe_four),
        .dsc_ack(dsc_ack), .dsc_rd(dsc_rd), .dsc_addr(dsc_addr),
        .take(fe_take), .idx(fe_idx), .last(fe_last)
    );

    dmac_addr_gen #(.AW(AW), .LW(LW)) u_agen (
        .clk(clk), .rst_n(rst_n), .load(state == ST_LOAD), .base(addr_q),
        .len(len_q), .stride(stride_q), .beat(beat),
        .addr(wr_addr), .last(ag_last), .half(ag_half)
    );

    // Channel state, setup registers, interrupt pulses and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            stride_q <= '0;
            link_q   <= '0;
            len_q    <= '0;
            cfg_q    <= '0;
            err      <= 1'b0;
            irq_done <= 1'b0;
            irq_half <= 1'b0;
        end else begin
            irq_done <= ag_last && cfg_q.done_en;
            irq_half <= ag_half && cfg_q.half_en;
            case (state)
                ST_IDLE: begin
                    if (reg_wr_en) begin
                        case (reg_wr_sel)
                            SEL_ADDR:   addr_q   <= reg_wr_data;
                            SEL_COUNT:  len_q    <= reg_wr_data[LW-1:0];
                            SEL_STRIDE: stride_q <= reg_wr_data;
                            SEL_PTR:    link_q   <= reg_wr_data;
                            SEL_CFG: begin
                                cfg_q <= cfg_new;
                                err   <= 1'b0;
                                if (fe_start)            state <= ST_FETCH;
                                else if (len_q == '0)    err   <= 1'b1;
                                else                     state <= ST_LOAD;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (fe_take) begin
                        case (fe_idx)
                            2'd0:    link_q <= dsc_data;
                            2'd1:    addr_q <= dsc_data;
                            2'd2:    len_q  <= dsc_data[LW-1:0];
                            default: cfg_q  <= chan_cfg_t'(dsc_data[CW-1:0]);
                        endcase
                    end
                    if (fe_last) begin
                        if (len_q == '0) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: state <= ST_RUN;
                default: begin
                    if (ag_last) begin
                        if (fe_start)                       state <= ST_FETCH;
                        else if (cfg_q.mode == MODE_REFRESH) state <= ST_LOAD;
                        else                                state <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dmac_chan_chk.sv
// Property checker for the DMA channel sequencer, attached by bind.
// It observes ports only.
module dmac_chan_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [2:0]    reg_wr_sel,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic          dsc_rd,
    input logic          irq_done,
    input logic          irq_half,
    input logic          err,
    input logic          busy
);
    // R1: an idle channel issues no requests of any kind
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !dsc_rd));

    // R3: a stalled write keeps its address
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_addr));

    // R5: the completion pulse follows an accepted word
    a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(wr_valid && wr_ready));

    // R6: the midpoint pulse follows an accepted word
    a_r6_half_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |-> $past(wr_valid && wr_ready));

    // R9: no data is offered while a descriptor read is pending
    a_r9_no_data_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_rd |-> !wr_valid);

    // R11: the error flag holds until a new start is written
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_wr_en && reg_wr_sel == 3'd3 && !busy)) |=> err);
endmodule

bind dmac_chan_ctrl dmac_chan_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dmac_chan_ctrl.sv
module sim_dmac_chan_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_wr_sel = '0;
    logic [AW-1:0] reg_wr_data = '0;
    logic          dsc_rd, src_ready, wr_valid, irq_done, irq_half, err, busy;
    logic [AW-1:0] dsc_addr, wr_addr, dsc_data;
    logic [DW-1:0] src_data, wr_data;
    logic          dsc_ack = 1'b1, src_valid = 1'b1, wr_ready = 1'b1;
    logic          stall = 1'b0;

    logic [31:0] mem [0:63];
    logic [31:0] exp_addr [0:63];
    logic [31:0] dsc_log [0:63];
    int done_pos [0:15];
    int half_pos [0:15];
    int nbeat = 0, nexp = 0, nd = 0, nh = 0, ndsc = 0;
    int cyc = 0, checks = 0, errors = 0;
    logic [15:0] src_cnt = '0;

    assign dsc_data = mem[dsc_addr[7:2]];
    assign src_data = {16'hD00D, src_cnt};

    always #4 clk = ~clk;

    dmac_chan_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .dsc_rd(dsc_rd), .dsc_addr(dsc_addr),
        .dsc_ack(dsc_ack), .dsc_data(dsc_data), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_done(irq_done), .irq_half(irq_half), .err(err), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Handshake stall pattern, driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (stall) begin
            src_valid = (cyc % 3) != 0;
            wr_ready  = (cyc % 4) != 1;
            dsc_ack   = (cyc % 5) != 3;
        end else begin
            src_valid = 1'b1;
            wr_ready  = 1'b1;
            dsc_ack   = 1'b1;
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: sample between edges, log pulses, reads and accepted words.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_done && nd < 16) begin done_pos[nd] = nbeat; nd++; end
            if (irq_half && nh < 16) begin half_pos[nh] = nbeat; nh++; end
            if (dsc_rd && dsc_ack && ndsc < 64) begin dsc_log[ndsc] = dsc_addr; ndsc++; end
            if (wr_valid && dsc_rd) chk(1'b0, "R9 data during fetch", 1, 0);
            if (wr_valid && wr_ready) begin
                if (nbeat < nexp && nbeat < 64)
                    chk(wr_addr == exp_addr[nbeat], "R2/R3 address", wr_addr, exp_addr[nbeat]);
                chk(wr_data == src_data, "R2 data passthrough", wr_data, src_data);
                nbeat++;
                src_cnt++;
            end
        end
    end

    task automatic clear_log();
        nbeat = 0; nd = 0; nh = 0; ndsc = 0; nexp = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_log();
    endtask

    task automatic regw(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) chk(1'b0, "watchdog idle", t, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_beats(input int n);
        int t = 0;
        while (nbeat < n && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) chk(1'b0, "watchdog beats", nbeat, n);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_oneshot(input logic [31:0] a, input int len, input int stride, input logic [4:0] cfg);
        clear_log();
        for (int k = 0; k < len; k++) exp_addr[k] = a + k * stride;
        nexp = len;
        regw(3'd0, a);
        regw(3'd1, len);
        regw(3'd2, stride);
        regw(3'd3, {27'd0, cfg});
        wait_idle();
        chk(nbeat == len, "R2 word count", nbeat, len);
        chk(!busy, "R2 halts after one buffer", busy, 0);
        if (cfg[3]) begin
            chk(nd == 1, "R5 one completion pulse", nd, 1);
            chk(done_pos[0] == len, "R5 completion position", done_pos[0], len);
        end else chk(nd == 0, "R5 completion disabled", nd, 0);
        if (cfg[4] && len >= 2) begin
            chk(nh == 1, "R6 one midpoint pulse", nh, 1);
            chk(half_pos[0] == len / 2, "R6 midpoint position", half_pos[0], len / 2);
        end else chk(nh == 0, "R6 no midpoint pulse", nh, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, wr_valid, src_ready, dsc_rd, irq_done, irq_half, err} == 7'd0,
            "R1 reset state", {busy, wr_valid, src_ready, dsc_rd, irq_done, irq_half, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_valid && !dsc_rd && !err, "R1 idle after reset", busy, 0);

        // R2 R3 R5 R6: sweep count and stride, with and without stalls
        stall = 1'b1;
        for (int len = 1; len <= 6; len++) begin
            for (int s = 0; s < 4; s++) begin
                int st;
                st = (s == 0) ? -4 : (s == 1) ? 0 : (s == 2) ? 4 : 12;
                run_oneshot(32'h0000_1000 + len * 32'h100, len, st, 5'b11000);
            end
        end
        stall = 1'b0;
        run_oneshot(32'h0000_8000, 4, -8, 5'b00000);
        run_oneshot(32'h0000_9000, 3, 4, 5'b01101); // reserved mode 5 acts as one-shot

        // R4 autorefresh repeats the programmed buffer; R12 writes while busy ignored
        do_reset();
        for (int k = 0; k < 9; k++) exp_addr[k] = 32'h100 + (k % 3) * 4;
        nexp = 9;
        stall = 1'b1;
        regw(3'd0, 32'h100);
        regw(3'd1, 3);
        regw(3'd2, 4);
        regw(3'd3, 32'h09);
        regw(3'd0, 32'h900); // R12: ignored while busy
        regw(3'd1, 7);       // R12: ignored while busy
        wait_beats(9);
        chk(nd >= 3, "R4 three completions", nd, 3);
        chk(done_pos[0] == 3 && done_pos[1] == 6 && done_pos[2] == 9, "R4 completion spacing",
            done_pos[2], 9);
        chk(busy, "R4 still running", busy, 1);
        stall = 1'b0;

        // R7 R10 linked list: two four-word sets, the second one-shot
        do_reset();
        mem[0] = 32'h10; mem[1] = 32'h2000; mem[2] = 2; mem[3] = 32'h0A;
        mem[4] = 32'h00; mem[5] = 32'h3000; mem[6] = 3; mem[7] = 32'h08;
        exp_addr[0] = 32'h2000; exp_addr[1] = 32'h2004;
        exp_addr[2] = 32'h3000; exp_addr[3] = 32'h3004; exp_addr[4] = 32'h3008;
        nexp = 5;
        stall = 1'b1;
        regw(3'd2, 4);
        regw(3'd4, 32'h0);
        regw(3'd3, 32'h02);
        wait_idle();
        stall = 1'b0;
        chk(nbeat == 5, "R10 list chains both sequences", nbeat, 5);
        chk(ndsc == 8, "R7 eight descriptor reads", ndsc, 8);
        for (int k = 0; k < 8; k++)
            if (k < ndsc) chk(dsc_log[k] == k * 4, "R7 descriptor read order", dsc_log[k], k * 4);
        chk(nd == 2 && done_pos[0] == 2 && done_pos[1] == 5, "R7 per-sequence completion", nd, 2);
        chk(!busy && !err, "R7 fetched one-shot config halts", busy, 0);

        // R8 R10 ping-pong ring: two-word sets, count and config kept
        do_reset();
        mem[8] = 32'h28; mem[9] = 32'h4000; mem[10] = 32'h20; mem[11] = 32'h5000;
        for (int k = 0; k < 8; k++)
            exp_addr[k] = ((k / 2) % 2 == 0 ? 32'h4000 : 32'h5000) + (k % 2) * 4;
        nexp = 8;
        regw(3'd1, 2);
        regw(3'd2, 4);
        regw(3'd4, 32'h20);
        regw(3'd3, 32'h0B);
        wait_beats(8);
        chk(ndsc >= 8, "R8 ring reads", ndsc, 8);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] e;
            e = 32'h20 + ((k / 2) % 2) * 8 + (k % 2) * 4;
            if (k < ndsc) chk(dsc_log[k] == e, "R8 ring read order", dsc_log[k], e);
        end
        chk(nd >= 4 && done_pos[3] == 8, "R8 count reused, R10 ring continues", done_pos[3], 8);

        // R11 zero length from a descriptor, then from the register
        do_reset();
        mem[12] = 32'h0; mem[13] = 32'h6000; mem[14] = 0; mem[15] = 32'h02;
        regw(3'd4, 32'h30);
        regw(3'd3, 32'h02);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(err, "R11 descriptor zero length flags error", err, 1);
        chk(!busy && nbeat == 0, "R11 channel halted, no data", nbeat, 0);
        regw(3'd1, 0);
        regw(3'd3, 32'h00);
        @(negedge clk);
        chk(err && !busy, "R11 register zero length", err, 1);
        run_oneshot(32'h7000, 1, 4, 5'b00000);
        chk(!err, "R11 error cleared by good start", err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule